// File: doc/BRIEF.md
# Half-Dot Character Pixel Serializer

This block turns one row of a character glyph into a serial dot stream for a raster display. From an 8-bit character code and a 4-bit scan-line counter it forms the address of the generator byte. It takes the byte that comes back and builds a 14-dot cell row, then shifts that row out one dot per dot clock, leftmost dot first.

The glyph encoding is unusual. Glyph bits 7 down to 2 each become a pair of identical dots. Glyph bits 1 and 0 are never drawn. They act as half-dot delay flags: bit 1 controls the left part of the cell and bit 0 controls the right part. When a flag is 0, that part of the cell moves one dot to the right.

Three attributes override the glyph:
- a force-on input for underline and cursor;
- a blank input;
- a reverse-video input, applied last.

Scan lines 8 to 15 of a character row are always dark unless force-on is set. The display timing logic pulses the load input once every 14 dot clocks, with the code, line, attributes and returned byte valid in that cycle.

Top module: `halfdot_pixel_serializer`

## Requirements
- R1: gen_addr_o equals char_code_i × 8 + line_i[2:0], combinationally; line_i[3] does not enter the address.
- R2: While rst_ni is low, and after reset until the first load, pix_o is 0.
- R3: On a clock edge with load_i high, a new 14-dot row is captured. pix_o shows row dot 13 after that edge and dot 13−k after k more edges with load_i low.
- R4: After the 14 dots of a row have been sent without a new load, pix_o stays 0.
- R5: With force_on_i = 1, every dot of the row is 1 before reverse video, whatever the glyph, blank_i or line_i.
- R6: With force_on_i = 0, every dot is 0 before reverse video when blank_i = 1 or line_i[3] = 1.
- R7: Otherwise glyph bit k (7 ≥ k ≥ 2) fills dots 2k−1 and 2k−2. Dots 1 and 0 come from the right part only. With glyph bits 1 and 0 both 1, the row is exactly this doubled pattern, with dot 0 at 0.
- R8: The left part of the row is dots 13..6. When glyph bit 1 is 0, those dots take the doubled pattern shifted right by one dot.
- R9: The right part of the row is dots 5..1. When glyph bit 0 is 0, those dots take the doubled pattern shifted right by one dot. Dot 0 is always 0 before reverse video.
- R10: With reverse_i = 1, every dot of the row is inverted after R5 and R6 are applied, so force-on with reverse gives an all-zero row.
- R11: A load in the middle of a cell drops the remaining dots and starts the new row from dot 13 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Row capture strobe, once per cell |
| char_code_i | input | 8 | Character code |
| line_i | input | 4 | Scan-line counter within the character row |
| gen_addr_o | output | 11 | Character generator address |
| glyph_i | input | 8 | Byte returned by the character generator |
| force_on_i | input | 1 | Underline/cursor: force all dots on |
| blank_i | input | 1 | Blank the cell |
| reverse_i | input | 1 | Reverse video |
| pix_o | output | 1 | Serial dot output |

## Verification
The bench sweeps all 256 glyph bytes under every combination of force-on, blank and reverse, with line values on both sides of line bit 3. Each assembled 14-dot row is compared with a model that works dot by dot.

A design that swapped the two delay flags, or tested them with the wrong polarity, would misplace the left or right part by one dot. The literal rows for bytes FC, FD, FE and FF expose this. A design that inverted before the force and blank rules would draw force-on with reverse as all ones.

Separate scenarios cover the other timing cases:
- Draining the shifter without a new load catches a design that recirculates the row instead of sending dark dots.
- A reload in the middle of a cell catches a design that finishes the old row first.

// File: rtl/halfdot_pkg.sv
package halfdot_pkg;
  localparam int unsigned GLYPH_W = 8;
  localparam int unsigned CELL_W  = 2 * (GLYPH_W - 1);
  localparam int unsigned SPLIT   = 6;  // first dot of the left segment

  typedef logic [CELL_W-1:0] cell_row_t;

  typedef struct packed {
    logic force_on;
    logic blank;
    logic reverse;
  } cell_attr_t;
endpackage

// File: rtl/halfdot_addr_gen.sv
module halfdot_addr_gen #(
  parameter int unsigned CODE_W  = 8,
  parameter int unsigned LINE_W  = 4,
  parameter int unsigned ROWSEL_W = 3
) (
  input  logic [CODE_W-1:0]          code_i,
  input  logic [LINE_W-1:0]          line_i,
  output logic [CODE_W+ROWSEL_W-1:0] addr_o,
  output logic                       line_hi_o
);
  assign addr_o    = {code_i, line_i[ROWSEL_W-1:0]};
  assign line_hi_o = line_i[LINE_W-1];
endmodule

// File: rtl/halfdot_row_expand.sv
module halfdot_row_expand
  import halfdot_pkg::*;
(
  input  logic [GLYPH_W-1:0] glyph_i,
  input  cell_attr_t         attr_i,
  input  logic               line_hi_i,
  output cell_row_t          row_o
);
  localparam cell_row_t LOW_BITS   = cell_row_t'((1 << SPLIT) - 1);
  localparam cell_row_t LEFT_MASK  = ~LOW_BITS;
  localparam cell_row_t RIGHT_MASK = LOW_BITS & ~cell_row_t'(1);

  cell_row_t dbl;
  cell_row_t left_seg, right_seg, base;

  assign dbl[1:0] = 2'b00;
  for (genvar k = 2; k < GLYPH_W; k++) begin : g_dbl
    assign dbl[2*k-1 -: 2] = {2{glyph_i[k]}};
  end

  // a cleared flag delays its segment by one dot
  assign left_seg  = (glyph_i[1] ? dbl : (dbl >> 1)) & LEFT_MASK;
  assign right_seg = (glyph_i[0] ? dbl : (dbl >> 1)) & RIGHT_MASK;

  always_comb begin
    if (attr_i.force_on)                    base = '1;
    else if (attr_i.blank || line_hi_i)     base = '0;
    else                                    base = left_seg | right_seg;
    row_o = attr_i.reverse ? ~base : base;
  end
endmodule

// File: rtl/halfdot_shifter.sv
module halfdot_shifter #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] row_i,
  output logic         pix_o
);
  localparam int unsigned CNT_W = $clog2(W + 1);

  logic [W-1:0] sreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sreg <= '0;
    else if (load_i) sreg <= row_i;
    else             sreg <= {sreg[W-2:0], 1'b0};
  end

  assign pix_o = sreg[W-1];

  // dots sent since the last load, saturating; used by the drain check
  logic [CNT_W-1:0] sent_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      sent_cnt <= CNT_W'(W);
    else if (load_i)                  sent_cnt <= '0;
    else if (sent_cnt < CNT_W'(W))    sent_cnt <= sent_cnt + 1'b1;
  end

  AST_LOAD_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (pix_o == $past(row_i[W-1]))); // R3
  AST_LOAD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i ##1 !load_i) |=> (pix_o == $past(row_i[W-2], 2))); // R11
  AST_DRAIN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sent_cnt >= CNT_W'(W - 1) && !load_i) |=> !pix_o); // R4
endmodule

// File: rtl/halfdot_pixel_serializer.sv
module halfdot_pixel_serializer
  import halfdot_pkg::*;
#(
  parameter int unsigned CODE_W   = 8,
  parameter int unsigned LINE_W   = 4,
  parameter int unsigned ROWSEL_W = 3,
  localparam int unsigned ADDR_W  = CODE_W + ROWSEL_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [CODE_W-1:0]  char_code_i,
  input  logic [LINE_W-1:0]  line_i,
  output logic [ADDR_W-1:0]  gen_addr_o,
  input  logic [GLYPH_W-1:0] glyph_i,
  input  logic               force_on_i,
  input  logic               blank_i,
  input  logic               reverse_i,
  output logic               pix_o
);
  logic       line_hi;
  cell_attr_t attr;
  cell_row_t  row;

  assign attr = '{force_on: force_on_i, blank: blank_i, reverse: reverse_i};

  halfdot_addr_gen #(
    .CODE_W  (CODE_W),
    .LINE_W  (LINE_W),
    .ROWSEL_W(ROWSEL_W)
  ) u_addr (
    .code_i   (char_code_i),
    .line_i   (line_i),
    .addr_o   (gen_addr_o),
    .line_hi_o(line_hi)
  );

  halfdot_row_expand u_expand (
    .glyph_i  (glyph_i),
    .attr_i   (attr),
    .line_hi_i(line_hi),
    .row_o    (row)
  );

  halfdot_shifter #(.W(CELL_W)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_i),
    .row_i (row),
    .pix_o (pix_o)
  );

  AST_FORCE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_on_i && !reverse_i) |-> (row == '1)); // R5
  AST_BLANK_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_on_i && (blank_i || line_i[LINE_W-1]) && !reverse_i) |-> (row == '0)); // R6
  AST_REV_AFTER_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_on_i && reverse_i) |-> (row == '0)); // R10
  AST_PAIR_DOTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_on_i && !blank_i && !line_i[LINE_W-1] && !reverse_i && glyph_i[1:0] == 2'b11)
      |-> (row[CELL_W-1] == row[CELL_W-2] && row[3] == row[2] && !row[0])); // R7
endmodule

// File: tb/halfdot_pixel_serializer_tb.sv
module halfdot_pixel_serializer_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [7:0]  code;
  logic [3:0]  line;
  logic [10:0] addr;
  logic [7:0]  glyph;
  logic        f_on, blank, rev;
  logic        pix;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  halfdot_pixel_serializer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .char_code_i(code),
    .line_i(line), .gen_addr_o(addr), .glyph_i(glyph),
    .force_on_i(f_on), .blank_i(blank), .reverse_i(rev), .pix_o(pix)
  );

  function automatic logic dbl_at(logic [7:0] g, int p);
    if (p >= 2 && p <= 13) return g[p/2 + 1];
    return 1'b0;
  endfunction

  function automatic logic glyph_dot(logic [7:0] g, int p);
    if (p >= 6) return g[1] ? dbl_at(g, p) : dbl_at(g, p + 1);
    if (p >= 1) return g[0] ? dbl_at(g, p) : dbl_at(g, p + 1);
    return 1'b0;
  endfunction

  function automatic logic [13:0] ref_row(logic [7:0] g, logic ln3, logic fo, logic bl, logic rv);
    logic [13:0] v;
    for (int p = 0; p < 14; p++) v[p] = glyph_dot(g, p);
    if (fo) v = '1;
    else if (bl || ln3) v = '0;
    if (rv) v = ~v;
    return v;
  endfunction

  function automatic string tag_for(logic [7:0] g, logic ln3, logic fo, logic bl, logic rv);
    if (rv) return "R10";
    if (fo) return "R5";
    if (bl || ln3) return "R6";
    if (!g[1]) return "R8";
    if (!g[0]) return "R9";
    return "R7";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge where dot 0 was sampled
  task automatic run_cell(logic [7:0] c, logic [3:0] l, logic [7:0] g,
                          logic fo, logic bl, logic rv, output logic [13:0] got);
    code = c; line = l; glyph = g; f_on = fo; blank = bl; rev = rv; load = 1'b1;
    #1 check("R1", 32'(addr), 32'({c, l[2:0]}));
    for (int i = 13; i >= 0; i--) begin
      @(negedge clk);
      load = 1'b0;
      got[i] = pix;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; load = 1'b0; code = '0; line = '0; glyph = '0;
    f_on = 1'b0; blank = 1'b0; rev = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", 32'(pix), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", 32'(pix), 32'd0);
  endtask

  task automatic t_literal_rows();
    logic [13:0] got;
    run_cell(8'h41, 4'd2, 8'hFF, 1'b0, 1'b0, 1'b0, got); check("R7", 32'(got), 32'h3FFC);
    run_cell(8'h42, 4'd3, 8'hFC, 1'b0, 1'b0, 1'b0, got); check("R8", 32'(got), 32'h1FFE);
    run_cell(8'h43, 4'd4, 8'hFE, 1'b0, 1'b0, 1'b0, got); check("R9", 32'(got), 32'h3FFE);
    run_cell(8'h44, 4'd5, 8'hFD, 1'b0, 1'b0, 1'b0, got); check("R8", 32'(got), 32'h1FFC);
    run_cell(8'h45, 4'd6, 8'hFF, 1'b1, 1'b0, 1'b1, got); check("R10", 32'(got), 32'h0000);
    run_cell(8'h46, 4'd9, 8'hFF, 1'b0, 1'b0, 1'b0, got); check("R6", 32'(got), 32'h0000);
    run_cell(8'h47, 4'd15, 8'h00, 1'b1, 1'b1, 1'b0, got); check("R5", 32'(got), 32'h3FFF);
  endtask

  task automatic t_sweep();
    logic [13:0] got;
    for (int g = 0; g < 256; g++) begin
      for (int a = 0; a < 8; a++) begin
        logic [3:0] l;
        l = 4'((g + a * 5) % 16);
        run_cell(8'(255 - g), l, 8'(g), a[0], a[1], a[2], got);
        check(tag_for(8'(g), l[3], a[0], a[1], a[2]), 32'(got),
              32'(ref_row(8'(g), l[3], a[0], a[1], a[2])));
      end
    end
  endtask

  task automatic t_drain();
    logic [13:0] got;
    run_cell(8'h10, 4'd0, 8'h00, 1'b1, 1'b0, 1'b0, got);
    check("R3", 32'(got), 32'h3FFF);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R4", 32'(pix), 32'd0);
    end
  endtask

  task automatic t_reload();
    logic [13:0] got;
    code = 8'h20; line = 4'd1; glyph = 8'h00; f_on = 1'b1; blank = 1'b0; rev = 1'b0; load = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      load = 1'b0;
      check("R11", 32'(pix), 32'd1);
    end
    run_cell(8'h21, 4'd1, 8'hFC, 1'b0, 1'b0, 1'b0, got);
    check("R11", 32'(got), 32'h1FFE);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_literal_rows();
    t_drain();
    t_reload();
    t_sweep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule